// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a 32-bit virtual address into a physical address by walking a two-level translation table held in memory. The translation buffer beside it calls it on a miss. The caller presents the virtual address together with the table base register. The walker then reads one first-level word. From that word it either finishes the walk (a 1 MB section or a fault) or goes on to read one word from a coarse or a fine second-level table. It then answers with the physical address, the page size and four attribute bits that are ready to load into the translation buffer, or it reports an abort.

Memory is reached through a plain read port that allows one outstanding access. The walker raises a read request with an address and holds both until the memory returns a one-cycle read-valid strobe with the data. Only one walk runs at a time. A new request is taken only while the walker is idle.

Top module: `pw_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_rd_req` and `rsp_valid` are 0. `req_ready` is 1 only while no walk is in progress. A request is taken only when `req_valid` and `req_ready` are both 1, and `req_va` and `req_base` are ignored at all other times.
- R2: The first read of every walk uses the address {base[31:14], va[31:20], 2'b00}.
- R3: Bits [1:0] of the first-level word select the walk: 00 fault (one read), 01 coarse table (two reads), 10 section (one read), 11 fine table (two reads).
- R4: A section result has pa = {L1[31:20], va[19:0]} and size code 11. Its attributes are {L1[11:10], L1[3:2]}.
- R5: A fault at either level gives `rsp_abort` = 1 with pa, size and attributes all zero.
- R6: The second read uses {L1[31:10], va[19:12], 2'b00} for a coarse table and {L1[31:12], va[19:10], 2'b00} for a fine table.
- R7: Bits [1:0] of the second-level word select 00 fault, 01 large page (pa = {L2[31:16], va[15:0]}, size 10), 10 small page (pa = {L2[31:12], va[11:0]}, size 01) or 11 tiny page (pa = {L2[31:10], va[9:0]}, size 00). Page attributes are {L2[5:4], L2[3:2]}.
- R8: A tiny-page word reached through a coarse table gives an abort.
- R9: While a read is pending, `mem_rd_req` stays 1 and `mem_rd_addr` stays stable until `mem_rd_valid` arrives. The walk does not advance before that strobe.
- R10: `rsp_valid` is a single-cycle pulse. In the cycle after it, `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request |
| req_va | input | 32 | Virtual address to translate |
| req_base | input | 32 | Table base register (bits 31:14 used) |
| req_ready | output | 1 | Walker idle, request accepted |
| mem_rd_req | output | 1 | Memory read request, held until served |
| mem_rd_addr | output | 32 | Word address of the table read |
| mem_rd_valid | input | 1 | Read data strobe |
| mem_rd_data | input | 32 | Table word read |
| rsp_valid | output | 1 | Walk result pulse |
| rsp_abort | output | 1 | Walk ended on a fault |
| rsp_pa | output | 32 | Physical address |
| rsp_size | output | 2 | 00 1 KB, 01 4 KB, 10 64 KB, 11 1 MB |
| rsp_attr | output | 4 | {permission[1:0], cache[1:0]} |

## Verification
Directed walks cover every first-level kind and every second-level kind under both coarse and fine tables. Together these separate the section splice from the three page splices, and the tiny-through-coarse abort from a legal tiny page under a fine table. Random first- and second-level words, addresses and base registers follow. The memory latency varies from zero to two wait cycles, which shows whether the walker really waits for the strobe. During each walk the request inputs are held active with different address values, which shows whether a busy walker ignores them. Read counts and both read addresses are compared on every walk, so a wrongly decoded kind shows up even when the final address happens to match.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int VA_W       = 32;
  localparam int WORD_SHIFT = 2;
  localparam int SEC_SHIFT   = 20;
  localparam int LARGE_SHIFT = 16;
  localparam int SMALL_SHIFT = 12;
  localparam int TINY_SHIFT  = 10;
  localparam int L1_IDX_W     = VA_W - SEC_SHIFT;
  localparam int COARSE_IDX_W = SEC_SHIFT - SMALL_SHIFT;
  localparam int FINE_IDX_W   = SEC_SHIFT - TINY_SHIFT;
  localparam int L1_TBL_SHIFT     = L1_IDX_W + WORD_SHIFT;
  localparam int COARSE_TBL_SHIFT = COARSE_IDX_W + WORD_SHIFT;
  localparam int FINE_TBL_SHIFT   = FINE_IDX_W + WORD_SHIFT;
  localparam int SEC_AP_LSB = 10;
  localparam int PG_AP_LSB  = 4;
  localparam int CB_LSB     = 2;
  localparam int ATTR_W     = 4;

  typedef enum logic [1:0] {L1_FAULT = 2'b00, L1_COARSE = 2'b01, L1_SECTION = 2'b10, L1_FINE = 2'b11} l1_kind_e;
  typedef enum logic [1:0] {L2_FAULT = 2'b00, L2_LARGE = 2'b01, L2_SMALL = 2'b10, L2_TINY = 2'b11} l2_kind_e;
  typedef enum logic [1:0] {SZ_1K = 2'b00, SZ_4K = 2'b01, SZ_64K = 2'b10, SZ_1M = 2'b11} pg_size_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RD1, ST_RD2, ST_RESP} walk_st_e;

  typedef struct packed {
    logic              abort;
    logic [VA_W-1:0]   pa;
    pg_size_e          size;
    logic [ATTR_W-1:0] attr;
  } walk_res_t;

  // Upper bits from the table word, low sh bits from the virtual address.
  function automatic logic [VA_W-1:0] splice(input logic [VA_W-1:0] hi,
                                             input logic [VA_W-1:0] lo,
                                             input int unsigned sh);
    logic [VA_W-1:0] m;
    m = (VA_W'(1) << sh) - VA_W'(1);
    return (hi & ~m) | (lo & m);
  endfunction
endpackage

// File: rtl/pw_l1_dec.sv
module pw_l1_dec
  import pw_pkg::*;
(
  input  logic [VA_W-1:0] entry,
  input  logic [VA_W-1:0] va,
  output l1_kind_e        kind,
  output logic [VA_W-1:0] l2_addr,
  output walk_res_t       sec_res
);
  logic [VA_W-1:0] coarse_addr;
  logic [VA_W-1:0] fine_addr;

  assign kind = l1_kind_e'(entry[1:0]);

  assign coarse_addr = {entry[VA_W-1:COARSE_TBL_SHIFT], va[SEC_SHIFT-1:SMALL_SHIFT], {WORD_SHIFT{1'b0}}};
  assign fine_addr   = {entry[VA_W-1:FINE_TBL_SHIFT],   va[SEC_SHIFT-1:TINY_SHIFT],  {WORD_SHIFT{1'b0}}};
  assign l2_addr     = (kind == L1_FINE) ? fine_addr : coarse_addr;

  always_comb begin
    sec_res       = '0;
    sec_res.pa    = splice(entry, va, SEC_SHIFT);
    sec_res.size  = SZ_1M;
    sec_res.attr  = {entry[SEC_AP_LSB +: 2], entry[CB_LSB +: 2]};
  end
endmodule

// File: rtl/pw_l2_dec.sv
module pw_l2_dec
  import pw_pkg::*;
(
  input  logic [VA_W-1:0] entry,
  input  logic [VA_W-1:0] va,
  input  logic            via_fine,
  output walk_res_t       res
);
  l2_kind_e kind;
  assign kind = l2_kind_e'(entry[1:0]);

  always_comb begin
    res      = '0;
    res.attr = {entry[PG_AP_LSB +: 2], entry[CB_LSB +: 2]};
    unique case (kind)
      L2_LARGE: begin res.pa = splice(entry, va, LARGE_SHIFT); res.size = SZ_64K; end
      L2_SMALL: begin res.pa = splice(entry, va, SMALL_SHIFT); res.size = SZ_4K;  end
      L2_TINY: begin
        if (via_fine) begin
          res.pa   = splice(entry, va, TINY_SHIFT);
          res.size = SZ_1K;
        end else begin
          res       = '0;
          res.abort = 1'b1;
        end
      end
      default: begin res = '0; res.abort = 1'b1; end
    endcase
  end
endmodule

// File: rtl/pw_walker.sv
module pw_walker
  import pw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_va,
  input  logic [31:0]       req_base,
  output logic              req_ready,
  output logic              mem_rd_req,
  output logic [31:0]       mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [31:0]       mem_rd_data,
  output logic              rsp_valid,
  output logic              rsp_abort,
  output logic [31:0]       rsp_pa,
  output logic [1:0]        rsp_size,
  output logic [3:0]        rsp_attr
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  walk_st_e        state_q, state_d;
  logic [VA_W-1:0] va_q, base_q, l2_addr_q;
  logic            fine_q;
  walk_res_t       res_q, res_d;
  logic            va_en, l2_en, res_en;

  l1_kind_e        l1_kind;
  logic [VA_W-1:0] l1_addr, l2_addr;
  walk_res_t       sec_res, pg_res;

  assign l1_addr = {base_q[VA_W-1:L1_TBL_SHIFT], va_q[VA_W-1:SEC_SHIFT], {WORD_SHIFT{1'b0}}};

  pw_l1_dec u_l1_dec (
    .entry   (mem_rd_data),
    .va      (va_q),
    .kind    (l1_kind),
    .l2_addr (l2_addr),
    .sec_res (sec_res)
  );

  pw_l2_dec u_l2_dec (
    .entry    (mem_rd_data),
    .va       (va_q),
    .via_fine (fine_q),
    .res      (pg_res)
  );

  always_comb begin
    state_d = state_q;
    va_en   = 1'b0;
    l2_en   = 1'b0;
    res_en  = 1'b0;
    res_d   = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        va_en   = 1'b1;
        state_d = ST_RD1;
      end
      ST_RD1: if (mem_rd_valid) begin
        unique case (l1_kind)
          L1_FAULT:   begin res_en = 1'b1; res_d.abort = 1'b1; state_d = ST_RESP; end
          L1_SECTION: begin res_en = 1'b1; res_d = sec_res;    state_d = ST_RESP; end
          default:    begin l2_en = 1'b1; state_d = ST_RD2; end
        endcase
      end
      ST_RD2: if (mem_rd_valid) begin
        res_en  = 1'b1;
        res_d   = pg_res;
        state_d = ST_RESP;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  always_ff @(posedge clk) begin
    if (va_en) begin
      va_q   <= req_va;
      base_q <= req_base;
    end
  end

  always_ff @(posedge clk) begin
    if (l2_en) begin
      l2_addr_q <= l2_addr;
      fine_q    <= (l1_kind == L1_FINE);
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign mem_rd_req  = (state_q == ST_RD1) || (state_q == ST_RD2);
  assign mem_rd_addr = (state_q == ST_RD2) ? l2_addr_q : l1_addr;
  assign rsp_valid   = (state_q == ST_RESP);
  assign rsp_abort   = res_q.abort;
  assign rsp_pa      = res_q.pa;
  assign rsp_size    = res_q.size;
  assign rsp_attr    = res_q.attr;
endmodule

// File: rtl/pw_walker_chk.sv
module pw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_rd_req,
  input logic [31:0] mem_rd_addr,
  input logic        mem_rd_valid,
  input logic        rsp_valid,
  input logic        rsp_abort,
  input logic [31:0] rsp_pa,
  input logic [1:0]  rsp_size,
  input logic [3:0]  rsp_attr
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_rd_req && !rsp_valid));

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R5
  abort_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_abort) |-> (rsp_pa == 32'h0 && rsp_size == 2'b00 && rsp_attr == 4'h0));

  // R9
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
endmodule

bind pw_walker pw_walker_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .mem_rd_req   (mem_rd_req),
  .mem_rd_addr  (mem_rd_addr),
  .mem_rd_valid (mem_rd_valid),
  .rsp_valid    (rsp_valid),
  .rsp_abort    (rsp_abort),
  .rsp_pa       (rsp_pa),
  .rsp_size     (rsp_size),
  .rsp_attr     (rsp_attr)
);

// File: tb/pw_walker_tb.sv
module pw_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [31:0] req_base = '0;
  logic        req_ready;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        rsp_valid, rsp_abort;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_size;
  logic [3:0]  rsp_attr;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  pw_walker u_dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_va (req_va), .req_base (req_base), .req_ready (req_ready),
    .mem_rd_req (mem_rd_req), .mem_rd_addr (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid), .mem_rd_data (mem_rd_data),
    .rsp_valid (rsp_valid), .rsp_abort (rsp_abort), .rsp_pa (rsp_pa),
    .rsp_size (rsp_size), .rsp_attr (rsp_attr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference model of one walk, written from the requirements
  task automatic model(input logic [31:0] va, input logic [31:0] base,
                       input logic [31:0] e1, input logic [31:0] e2,
                       output logic [31:0] a1, output logic [31:0] a2, output int nrd,
                       output logic ab, output logic [31:0] pa, output logic [1:0] sz,
                       output logic [3:0] at, output string tag);
    a1 = {base[31:14], va[31:20], 2'b00};
    a2 = '0; ab = 1'b0; pa = '0; sz = 2'b00; at = 4'h0; nrd = 1;
    case (e1[1:0])
      2'b00: begin ab = 1'b1; tag = "R5"; end
      2'b10: begin pa = {e1[31:20], va[19:0]}; sz = 2'b11; at = {e1[11:10], e1[3:2]}; tag = "R4"; end
      default: begin
        nrd = 2;
        a2 = (e1[1:0] == 2'b01) ? {e1[31:10], va[19:12], 2'b00} : {e1[31:12], va[19:10], 2'b00};
        tag = "R7";
        at = {e2[5:4], e2[3:2]};
        case (e2[1:0])
          2'b00: begin ab = 1'b1; tag = "R5"; end
          2'b01: begin pa = {e2[31:16], va[15:0]}; sz = 2'b10; end
          2'b10: begin pa = {e2[31:12], va[11:0]}; sz = 2'b01; end
          default: begin
            if (e1[1:0] == 2'b01) begin ab = 1'b1; tag = "R8"; end
            else begin pa = {e2[31:10], va[9:0]}; sz = 2'b00; end
          end
        endcase
        if (ab) at = 4'h0;
      end
    endcase
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] base,
                      input logic [31:0] e1, input logic [31:0] e2);
    logic [31:0] a1, a2, pa;
    logic        ab;
    logic [1:0]  sz;
    logic [3:0]  at;
    int          nrd, reads, waitc, cyc;
    bit          got;
    string       tag;
    logic        g_ab;
    logic [31:0] g_pa;
    logic [1:0]  g_sz;
    logic [3:0]  g_at;
    model(va, base, e1, e2, a1, a2, nrd, ab, pa, sz, at, tag);
    @(negedge clk);
    chk("R1", "ready before request", {31'b0, req_ready}, 32'h1);
    req_valid = 1'b1; req_va = va; req_base = base;
    @(negedge clk);
    // R1: busy walker must ignore these changed request inputs
    req_va = ~va; req_base = ~base;
    reads = 0; waitc = $urandom % 3; got = 0; cyc = 0;
    g_ab = 1'b0; g_pa = '0; g_sz = '0; g_at = '0;
    while (!got && cyc < 40) begin
      mem_rd_valid = 1'b0;
      if (rsp_valid) begin
        got = 1;
        g_ab = rsp_abort; g_pa = rsp_pa; g_sz = rsp_size; g_at = rsp_attr;
        req_valid = 1'b0;
      end else if (mem_rd_req) begin
        if (reads >= 2) begin
          chk("R3", "extra read", 32'(reads), 32'(nrd));
          reads++;
        end else if (waitc == 0) begin
          chk(reads == 0 ? "R2" : "R6", "read address", mem_rd_addr, reads == 0 ? a1 : a2);
          mem_rd_valid = 1'b1;
          mem_rd_data  = (reads == 0) ? e1 : e2;
          reads++;
          waitc = $urandom % 3;
        end else begin
          chk("R9", "held address", mem_rd_addr, reads == 0 ? a1 : a2);
          waitc--;
        end
      end
      if (!got) begin
        @(negedge clk);
        cyc++;
      end
    end
    req_valid = 1'b0;
    mem_rd_valid = 1'b0;
    chk("R9", "walk completed", {31'b0, got}, 32'h1);
    chk("R3", "read count", 32'(reads), 32'(nrd));
    chk(tag, "abort", {31'b0, g_ab}, {31'b0, ab});
    chk(tag, "pa", g_pa, pa);
    chk(tag, "size", {30'b0, g_sz}, {30'b0, sz});
    chk(tag, "attr", {28'b0, g_at}, {28'b0, at});
    @(negedge clk);
    chk("R10", "rsp pulse ended", {31'b0, rsp_valid}, 32'h0);
    chk("R10", "ready after rsp", {31'b0, req_ready}, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "reset ready", {31'b0, req_ready}, 32'h1);
    chk("R1", "reset no read", {31'b0, mem_rd_req}, 32'h0);
    chk("R1", "reset no rsp", {31'b0, rsp_valid}, 32'h0);

    // directed: every kind at both levels
    walk(32'h1234_5678, 32'hABCD_C000, 32'h8760_0C0E, 32'h0);         // section R4
    walk(32'hFFF0_0001, 32'h0000_4000, 32'h1234_5670, 32'h0);         // L1 fault R5
    walk(32'h0123_4567, 32'h1000_0000, 32'h2000_0401, 32'hABCD_0035); // coarse large R7
    walk(32'h0123_4567, 32'h1000_0000, 32'h2000_0401, 32'hABCD_E03A); // coarse small R7
    walk(32'h0123_4567, 32'h1000_0000, 32'h2000_0401, 32'hABCD_E43F); // coarse tiny R8
    walk(32'h0123_4567, 32'h1000_0000, 32'h2000_0401, 32'hABCD_E43C); // coarse fault R5
    walk(32'h89AB_CDEF, 32'h2000_8000, 32'h3000_1003, 32'h5555_0015); // fine large R7
    walk(32'h89AB_CDEF, 32'h2000_8000, 32'h3000_1003, 32'h5555_502A); // fine small R7
    walk(32'h89AB_CDEF, 32'h2000_8000, 32'h3000_1003, 32'h5555_5C3F); // fine tiny R7
    walk(32'h89AB_CDEF, 32'h2000_8000, 32'h3000_1003, 32'h5555_5C30); // fine fault R5
    walk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFF0_0C0E, 32'h0);         // section, all ones

    // random walks
    for (int i = 0; i < 300; i++)
      walk($urandom, $urandom, $urandom, $urandom);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule